// File: doc/BRIEF.md
# Dual-Channel Timer Register Front-End

This block is the bus-facing part of a two-channel timer peripheral. It sits on an APB port with a 4 KB window, decodes each word address into one register of one timer channel, and turns access-phase writes into single-cycle write strobes for the external channel logic. On reads it selects the channel's load, count, control and status values. Both channels share one 32-byte register layout, and address bit 5 picks the channel. The counters live outside this block and connect through the strobe and read-data ports. They take their write data straight from `pwdata`.

The block also owns two integration-test registers. One is a single enable bit. The other is a write-only pair of output bits. While the enable bit is set, the two interrupt outputs follow those bits and no longer follow the channels' masked status. A combined interrupt is the OR of the two per-channel lines. The top of the window returns a fixed set of twelve identification bytes.

A three-state phase tracker follows the APB handshake. The states are `PH_IDLE` (no select), `PH_SETUP` (select without enable) and `PH_ACCESS` (select with enable). From any state the tracker goes to `PH_IDLE` when select is low, to `PH_SETUP` when select is high and enable is low, and to `PH_ACCESS` when both are high. A write strobe or a test-register write only fires in an access cycle that directly follows a `PH_SETUP` cycle. This rule blocks a second commit when enable is held high.

Top module: `dtf_apb_frontend`

## Requirements
- R1: An APB write in the access cycle, with the previous cycle a setup cycle, pulses exactly one strobe for one cycle. The strobe belongs to channel 0 for offsets 0x00-0x1F and channel 1 for 0x20-0x3F. Word offset 0x00 selects `ld_wr`, 0x08 `ctrl_wr`, 0x0C `iclr_wr` and 0x18 `bgld_wr`, and bit c of each strobe names channel c. No strobe is high during a setup cycle or for a read.
- R2: Within a channel, reads return:
  - offsets 0x00 and 0x18: that channel's `ld_rdata` word;
  - offset 0x04: its `val_rdata` word;
  - offset 0x08: its 8-bit `ctl_rdata`, zero-extended;
  - offset 0x10: raw status bit `ris_in[c]` in bit 0;
  - offset 0x14: masked status bit `mis_in[c]` in bit 0.
- R3: The test enable register at 0xF00 stores `pwdata[0]`, reads back in bit 0 and resets to 0.
- R4: The test output register at 0xF04 stores `pwdata[1:0]`, resets to 0 and always reads as zero.
- R5: While test enable is 1, `irq_ch[0]` equals test output bit 0 and `irq_ch[1]` equals test output bit 1, whatever the status inputs are.
- R6: While test enable is 0, `irq_ch[c]` equals `mis_in[c]`.
- R7: `irq_any` is the OR of `irq_ch[1:0]`.
- R8: Words 0xFD0 through 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: These reads return zero: offsets 0x0C and 0x1C inside a channel, anything from 0x40 to 0xEFC, 0xF08 to 0xFCC, and the write-only test output register. A write to an unmapped offset, or to a channel's 0x04, 0x10 or 0x14, raises no strobe and leaves both test registers unchanged. Address bits [1:0] are ignored.
- R10: `pready` is always 1 and `pslverr` always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write direction |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Ready, always high |
| pslverr | output | 1 | Error, always low |
| ld_wr | output | 2 | Per-channel load write strobe |
| ctrl_wr | output | 2 | Per-channel control write strobe |
| iclr_wr | output | 2 | Per-channel interrupt clear strobe |
| bgld_wr | output | 2 | Per-channel background load write strobe |
| ld_rdata | input | 64 | Reload values, channel c in bits [32c+31:32c] |
| val_rdata | input | 64 | Current counts, channel c in bits [32c+31:32c] |
| ctl_rdata | input | 16 | Control bytes, channel c in bits [8c+7:8c] |
| ris_in | input | 2 | Raw interrupt status per channel |
| mis_in | input | 2 | Masked interrupt status per channel |
| irq_ch | output | 2 | Per-channel interrupt outputs |
| irq_any | output | 1 | Combined interrupt |

## Verification
The read path is checked with a table of addresses. The two channels carry deliberately different values, and the raw and masked status bits are set in opposite senses, so a wrong channel index or a swapped status offset gives a visible mismatch. The same table covers the holes inside a channel, the gaps between regions and every identification word.

Writes are applied to each strobe offset of both channels, and the bench samples the strobe vector in the setup and access cycles. This separates a wrong strobe, a wrong channel and a strobe that fires too early. Write-only and unmapped writes are then followed by read-back and interrupt observation.

The interrupt mux is exercised in both modes. In test mode, test patterns are applied that disagree with the status inputs. In normal mode, status patterns are applied while the test bits are set to other values.

// File: rtl/dtf_pkg.sv
package dtf_pkg;

    typedef enum logic [3:0] {
        RG_NONE, RG_LOAD, RG_VALUE, RG_CTRL, RG_ICLR, RG_RIS, RG_MIS,
        RG_BGLOAD, RG_ITEN, RG_ITOUT, RG_IDENT
    } reg_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_ACCESS
    } phase_e;

    localparam int TEST_EN_OFF  = 'hF00;
    localparam int TEST_OUT_OFF = 'hF04;
    localparam int IDENT_BASE   = 'hFD0;
    localparam int IDENT_WORDS  = 12;
    localparam int CH_SPAN_BITS = 5;

    function automatic logic [7:0] ident_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h23;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dtf_decode.sv
module dtf_decode
    import dtf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] paddr,
    output reg_e              kind,
    output logic [CH_W-1:0]   ch,
    output logic [3:0]        ident_idx
);
    localparam int HI_W = ADDR_W - CH_SPAN_BITS;

    logic [HI_W-1:0]   block_no;
    logic [ADDR_W-1:0] word_addr;
    logic [ADDR_W-1:0] ident_off;

    assign block_no  = paddr[ADDR_W-1:CH_SPAN_BITS];
    assign word_addr = {paddr[ADDR_W-1:2], 2'b00};
    assign ident_off = word_addr - ADDR_W'(IDENT_BASE);
    assign ch        = paddr[CH_SPAN_BITS +: CH_W];
    assign ident_idx = ident_off[5:2];

    always_comb begin
        kind = RG_NONE;
        if (int'(block_no) < NUM_CH) begin
            unique case (paddr[4:2])
                3'd0:    kind = RG_LOAD;
                3'd1:    kind = RG_VALUE;
                3'd2:    kind = RG_CTRL;
                3'd3:    kind = RG_ICLR;
                3'd4:    kind = RG_RIS;
                3'd5:    kind = RG_MIS;
                3'd6:    kind = RG_BGLOAD;
                default: kind = RG_NONE;
            endcase
        end else if (word_addr == ADDR_W'(TEST_EN_OFF)) begin
            kind = RG_ITEN;
        end else if (word_addr == ADDR_W'(TEST_OUT_OFF)) begin
            kind = RG_ITOUT;
        end else if (int'(word_addr) >= IDENT_BASE &&
                     int'(word_addr) < IDENT_BASE + 4 * IDENT_WORDS) begin
            kind = RG_IDENT;
        end
    end

endmodule

// File: rtl/dtf_itest.sv
module dtf_itest #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              out_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] mis_in,
    output logic              test_en,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);
    logic [NUM_CH-1:0] test_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_en  <= 1'b0;
            test_out <= '0;
        end else begin
            if (en_we)  test_en  <= wbits[0];
            if (out_we) test_out <= wbits;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        assign irq_ch[c] = test_en ? test_out[c] : mis_in[c];
    end
    assign irq_any = |irq_ch;

    // R3
    test_en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> test_en == $past(wbits[0]));

    // R5
    test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_out == '0) |-> !irq_any);

    // R7
    any_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> irq_ch != '0);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_we |=> $stable(test_out));

endmodule

// File: rtl/dtf_apb_frontend.sv
module dtf_apb_frontend
    import dtf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2,
    parameter int CTRL_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [DATA_W-1:0]        pwdata,
    output logic [DATA_W-1:0]        prdata,
    output logic                     pready,
    output logic                     pslverr,
    output logic [NUM_CH-1:0]        ld_wr,
    output logic [NUM_CH-1:0]        ctrl_wr,
    output logic [NUM_CH-1:0]        iclr_wr,
    output logic [NUM_CH-1:0]        bgld_wr,
    input  logic [NUM_CH*DATA_W-1:0] ld_rdata,
    input  logic [NUM_CH*DATA_W-1:0] val_rdata,
    input  logic [NUM_CH*CTRL_W-1:0] ctl_rdata,
    input  logic [NUM_CH-1:0]        ris_in,
    input  logic [NUM_CH-1:0]        mis_in,
    output logic [NUM_CH-1:0]        irq_ch,
    output logic                     irq_any
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    phase_e           phase_q, phase_d;
    reg_e             kind;
    logic [CH_W-1:0]  ch;
    logic [3:0]       ident_idx;
    logic             wr_commit;
    logic             test_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_SETUP, PH_ACCESS: begin
                if (!psel)         phase_d = PH_IDLE;
                else if (!penable) phase_d = PH_SETUP;
                else               phase_d = PH_ACCESS;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign wr_commit = psel && penable && pwrite && (phase_q == PH_SETUP);
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

    dtf_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .paddr     (paddr),
        .kind      (kind),
        .ch        (ch),
        .ident_idx (ident_idx)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_stb
        logic hit;
        assign hit        = wr_commit && (ch == CH_W'(c));
        assign ld_wr[c]   = hit && (kind == RG_LOAD);
        assign ctrl_wr[c] = hit && (kind == RG_CTRL);
        assign iclr_wr[c] = hit && (kind == RG_ICLR);
        assign bgld_wr[c] = hit && (kind == RG_BGLOAD);
    end

    dtf_itest #(.NUM_CH(NUM_CH)) u_itest (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (wr_commit && kind == RG_ITEN),
        .out_we  (wr_commit && kind == RG_ITOUT),
        .wbits   (pwdata[NUM_CH-1:0]),
        .mis_in  (mis_in),
        .test_en (test_en),
        .irq_ch  (irq_ch),
        .irq_any (irq_any)
    );

    always_comb begin
        prdata = '0;
        unique case (kind)
            RG_LOAD, RG_BGLOAD: prdata = ld_rdata[ch*DATA_W +: DATA_W];
            RG_VALUE:           prdata = val_rdata[ch*DATA_W +: DATA_W];
            RG_CTRL:            prdata = DATA_W'(ctl_rdata[ch*CTRL_W +: CTRL_W]);
            RG_RIS:             prdata = DATA_W'(ris_in[ch]);
            RG_MIS:             prdata = DATA_W'(mis_in[ch]);
            RG_ITEN:            prdata = DATA_W'(test_en);
            RG_IDENT:           prdata = DATA_W'(ident_byte(ident_idx));
            default:            prdata = '0;
        endcase
    end

    // R1
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |-> (ld_wr | ctrl_wr | iclr_wr | bgld_wr) == '0);

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_wr, ctrl_wr, iclr_wr, bgld_wr}));

    // R1
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr | ctrl_wr | iclr_wr | bgld_wr) != '0
        |=> (ld_wr | ctrl_wr | iclr_wr | bgld_wr) == '0);

endmodule

// File: tb/dtf_apb_frontend_test.sv
module dtf_apb_frontend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [1:0]  ld_wr, ctrl_wr, iclr_wr, bgld_wr;
    logic [63:0] ld_rdata  = {32'h2222_0001, 32'h1111_0000};
    logic [63:0] val_rdata = {32'h1234_5678, 32'hAAAA_5555};
    logic [15:0] ctl_rdata = {8'hE3, 8'h25};
    logic [1:0]  ris_in = 2'b01;
    logic [1:0]  mis_in = 2'b00;
    logic [1:0]  irq_ch;
    logic        irq_any;
    logic [7:0]  stbvec;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign stbvec = {ld_wr, ctrl_wr, iclr_wr, bgld_wr};

    dtf_apb_frontend uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ld_wr(ld_wr), .ctrl_wr(ctrl_wr), .iclr_wr(iclr_wr),
        .bgld_wr(bgld_wr), .ld_rdata(ld_rdata), .val_rdata(val_rdata),
        .ctl_rdata(ctl_rdata), .ris_in(ris_in), .mis_in(mis_in),
        .irq_ch(irq_ch), .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic [7:0] stb);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
        #1 chk("R1 no strobe in setup", 32'(stbvec), 32'h0);
        @(negedge clk);
        penable = 1;
        #1 rd = prdata; stb = stbvec;
        chk("R10 ready/err", {30'h0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    // entries: {address, expected read}; channel inputs fixed above, mis_in = 2'b10
    localparam int NV = 30;
    localparam logic [43:0] RD_TAB [NV] = '{
        {12'h000, 32'h1111_0000},  // R2 ch0 load
        {12'h004, 32'hAAAA_5555},  // R2 ch0 value
        {12'h008, 32'h0000_0025},  // R2 ch0 control
        {12'h00C, 32'h0},          // R9 clear offset reads zero
        {12'h010, 32'h1},          // R2 ch0 raw
        {12'h014, 32'h0},          // R2 ch0 masked
        {12'h018, 32'h1111_0000},  // R2 ch0 background load
        {12'h01C, 32'h0},          // R9 hole
        {12'h020, 32'h2222_0001},  // R2 ch1 load
        {12'h024, 32'h1234_5678},  // R2 ch1 value
        {12'h028, 32'h0000_00E3},  // R2 ch1 control
        {12'h02E, 32'h0},          // R9 low bits ignored
        {12'h030, 32'h0},          // R2 ch1 raw
        {12'h034, 32'h1},          // R2 ch1 masked
        {12'h03A, 32'h2222_0001},  // R2 R9 bgload with low bits set
        {12'h040, 32'h0},          // R9
        {12'h100, 32'h0},          // R9
        {12'hF04, 32'h0},          // R4 write-only
        {12'hF08, 32'h0},          // R9
        {12'hFCC, 32'h0},          // R9
        {12'hFD0, 32'h04},         // R8
        {12'hFDC, 32'h00},         // R8
        {12'hFE0, 32'h23},         // R8
        {12'hFE4, 32'hB8},         // R8
        {12'hFE8, 32'h1B},         // R8
        {12'hFEC, 32'h00},         // R8
        {12'hFF0, 32'h0D},         // R8
        {12'hFF4, 32'hF0},         // R8
        {12'hFF8, 32'h05},         // R8
        {12'hFFC, 32'hB1}          // R8
    };

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  stb;
        logic [11:0] offs [4];
        offs = '{12'h000, 12'h008, 12'h00C, 12'h018};

        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state: R3, R6, R7
        xfer(0, 12'hF00, 0, rd, stb);
        chk("R3 reset test enable", rd, 32'h0);
        #1 chk("R6 R7 reset irq", {29'h0, irq_any, irq_ch}, 32'h0);

        mis_in = 2'b10;
        for (int i = 0; i < NV; i++) begin
            xfer(0, RD_TAB[i][43:32], 32'h0, rd, stb);
            chk($sformatf("R2 R8 R9 read @%h", RD_TAB[i][43:32]), rd, RD_TAB[i][31:0]);
            chk("R1 no strobe on read", 32'(stb), 32'h0);
        end

        // R1 strobe per channel and register
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                xfer(1, offs[r] + 12'(c * 32), 32'hFFFF_FFFF, rd, stb);
                chk($sformatf("R1 strobe c%0d r%0d", c, r), 32'(stb),
                    32'(8'(1) << ((3 - r) * 2 + c)));
            end
        end

        // R9 writes to non-strobe or unmapped offsets
        xfer(1, 12'h004, 32'h1, rd, stb); chk("R9 value write no strobe", 32'(stb), 0);
        xfer(1, 12'h034, 32'h1, rd, stb); chk("R9 masked write no strobe", 32'(stb), 0);
        xfer(1, 12'h05C, 32'h1, rd, stb); chk("R9 unmapped write no strobe", 32'(stb), 0);

        // R6 normal mode follows status with test bits set otherwise
        xfer(1, 12'hF04, 32'h1, rd, stb);
        #1 chk("R6 normal mode follows status", {29'h0, irq_any, irq_ch}, 32'h6);
        xfer(0, 12'hF04, 0, rd, stb);
        chk("R4 test output reads zero", rd, 32'h0);

        // R5 test mode
        xfer(1, 12'hF00, 32'h1, rd, stb);
        #1 chk("R5 override bit0", {29'h0, irq_any, irq_ch}, 32'h5);
        xfer(0, 12'hF00, 0, rd, stb);
        chk("R3 test enable readback", rd, 32'h1);
        mis_in = 2'b11;
        xfer(1, 12'hF04, 32'h2, rd, stb);
        #1 chk("R5 override bit1", {29'h0, irq_any, irq_ch}, 32'h6);
        xfer(1, 12'hF04, 32'h0, rd, stb);
        #1 chk("R5 R7 override quiet", {29'h0, irq_any, irq_ch}, 32'h0);

        // R9 unmapped write leaves test registers alone
        xfer(1, 12'hF08, 32'hFFFF_FFFF, rd, stb);
        #1 chk("R9 test out unchanged", {29'h0, irq_any, irq_ch}, 32'h0);
        xfer(0, 12'hF00, 0, rd, stb);
        chk("R9 test enable unchanged", rd, 32'h1);

        // back to normal mode
        mis_in = 2'b01;
        xfer(1, 12'hF00, 32'h0, rd, stb);
        #1 chk("R6 R7 status after exit", {29'h0, irq_any, irq_ch}, 32'h5);
        mis_in = 2'b00;
        #1 chk("R7 combined low", {29'h0, irq_any, irq_ch}, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule